// File: doc/BRIEF.md
# Position Encoder Clock Burst Generator

This block drives the clock line that a single master sends to an absolute position encoder on a synchronous serial link. Each frame is a burst of clock cycles, one for each bit of the position word. A bit cycle starts on a tick from a base-rate timebase. The line goes low for a fixed number of system clocks and then returns high until the next tick. The encoder shifts out its multiturn bits first and its single-turn bits after them, one bit per cycle. The default is 25 bits: 12 multiturn bits and 13 single-turn bits.

Between bursts the line stays high for a long, exactly counted gap. The default gap is 25 tick periods, which is 250 µs at a 100 kHz tick. This is far longer than the encoder's own refresh time of 10 to 40 µs. Any passive listener on the data line, which has no clock of its own, can therefore detect the start of a frame by timing the idle period. When a burst ends, the bit count reloads itself. Frames repeat with no outside action for as long as the enable stays high. If the enable drops, the current burst still finishes, and the line then stays high.

Top module: `ssi_clk_burst`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ssi_clk` is 1 and `frame_act` is 0.
- R2: Every burst contains exactly `BITS` low pulses on `ssi_clk`, and every later burst also contains `BITS` pulses with no outside reload.
- R3: Inside a burst, a tick that arrives while the line is high starts the next bit. `ssi_clk` is low from the cycle after that tick for exactly `HALF_CYC` system cycles and is then high. A tick that arrives while the line is low is ignored.
- R4: A new burst starts on the tick that follows `GAP_TICKS` ticks counted after the end of the previous burst (or after reset). Ticks count only while no burst is active. The first falling edge appears in the cycle after that tick.
- R5: While no burst is active, `ssi_clk` is held at 1.
- R6: `frame_act` rises in the same cycle as the first falling edge of a burst. It falls in the same cycle as the last rising edge of that burst.
- R7: Deasserting `en` during a burst does not shorten it: all `BITS` pulses are still produced.
- R8: A burst starts only on a tick at which `en` is 1. With `en` at 0 once the gap has elapsed, the line stays high. The burst starts on the first tick at which `en` is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Allows new bursts to start |
| tick | input | 1 | One-cycle strobe at the bit rate |
| ssi_clk | output | 1 | Clock level driven to the encoder, idle high |
| frame_act | output | 1 | High from the first falling edge to the last rising edge of a burst |

## Verification
The bench varies the spacing between ticks, so it can catch a gap counter that counts system cycles instead of ticks, or that also counts the tick arriving at the edge where a burst ends. Either fault moves the next burst by one tick period. It drops `en` in the middle of bursts and holds it low across the gap. A design that aborts the burst would give a short pulse count, and one that samples `en` at the wrong moment would start a burst early. Every burst's pulse count is checked against `BITS`, which exposes a missing or off-by-one reload. The alignment of `frame_act` with the first falling and last rising edges is checked every cycle, which catches a flag that lags by one cycle.

// File: rtl/ssi_clk_burst.sv
module ssi_clk_burst #(
  parameter int BITS      = 25,
  parameter int GAP_TICKS = 25,
  parameter int HALF_CYC  = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  output logic ssi_clk,
  output logic frame_act
);
  localparam int BW = $clog2(BITS + 1);
  localparam int GW = $clog2(GAP_TICKS + 1);
  localparam int HW = $clog2(HALF_CYC + 1);

  logic [BW-1:0] bits_left;
  logic [GW-1:0] gap_cnt;
  logic [HW-1:0] half_cnt;
  logic          busy, line;

  wire gap_done = (gap_cnt == '0);
  wire start    = !busy && tick && en && gap_done;
  wire next_bit = busy && tick && line && (bits_left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      line      <= 1'b1;
      bits_left <= '0;
      half_cnt  <= '0;
      gap_cnt   <= GW'(GAP_TICKS);
    end else begin
      if (start) begin
        busy      <= 1'b1;
        line      <= 1'b0;
        bits_left <= BW'(BITS - 1);
        half_cnt  <= HW'(HALF_CYC - 1);
      end else if (next_bit) begin
        line      <= 1'b0;
        bits_left <= bits_left - 1'b1;
        half_cnt  <= HW'(HALF_CYC - 1);
      end else if (busy && !line) begin
        if (half_cnt != '0) half_cnt <= half_cnt - 1'b1;
        else begin
          line <= 1'b1;
          if (bits_left == '0) begin
            busy    <= 1'b0;
            gap_cnt <= GW'(GAP_TICKS);
          end
        end
      end
      if (!busy && tick && !gap_done) gap_cnt <= gap_cnt - 1'b1;
    end
  end

  assign ssi_clk   = line;
  assign frame_act = busy;

  AST_IDLE_HIGH:   assert property (@(posedge clk) disable iff (!rst_n) !frame_act |-> ssi_clk);                  // R5
  AST_FIRST_FALL:  assert property (@(posedge clk) disable iff (!rst_n) $rose(frame_act) |-> $fell(ssi_clk));      // R6
  AST_LAST_RISE:   assert property (@(posedge clk) disable iff (!rst_n) $fell(frame_act) |-> $rose(ssi_clk));      // R6
  AST_START_GAP:   assert property (@(posedge clk) disable iff (!rst_n) $rose(frame_act) |-> $past(gap_cnt) == '0); // R4
  AST_START_EN:    assert property (@(posedge clk) disable iff (!rst_n) $rose(frame_act) |-> $past(en) && $past(tick)); // R8
  AST_BIT_RANGE:   assert property (@(posedge clk) disable iff (!rst_n) bits_left <= BW'(BITS - 1));               // R2
  AST_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) $fell(ssi_clk) |-> $past(tick));          // R3
endmodule

// File: tb/tb_ssi_clk_burst.sv
module tb_ssi_clk_burst;
  localparam int BITS = 25, GAP = 25, HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, tick = 1'b0;
  logic ssi_clk, frame_act;
  int vectors = 0, fails = 0;

  ssi_clk_burst #(.BITS(BITS), .GAP_TICKS(GAP), .HALF_CYC(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
    .ssi_clk(ssi_clk), .frame_act(frame_act));

  always #5 clk = ~clk;

  // spec model state
  bit m_busy = 0, m_line = 1;
  int m_left = 0, m_low = 0, m_ticks = 0;
  // measurement state
  int falls = 0, gap_ticks = 0, frames = 0;
  bit en_dropped = 0, en_gap_low = 0, p_ssi = 1, p_frame = 0;

  task automatic check(input bit got, input bit exp, input string req);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic check_int(input int got, input int exp, input string req);
    vectors++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  function automatic int next_gap();
    return 6 + int'($urandom % 7);
  endfunction

  task automatic model_step(input bit t, input bit e);
    if (!m_busy) begin
      if (t) begin
        if (m_ticks >= GAP && e) begin
          m_busy = 1; m_line = 0; m_left = BITS - 1; m_low = 1;
        end else if (m_ticks < GAP) m_ticks++;
      end
    end else if (t && m_line && m_left > 0) begin
      m_line = 0; m_left--; m_low = 1;
    end else if (!m_line) begin
      if (m_low == HALF) begin
        m_line = 1;
        if (m_left == 0) begin m_busy = 0; m_ticks = 0; end
      end else m_low++;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : main
    int tcnt;
    int hold_low;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(ssi_clk, 1'b1, "R1");
    check(frame_act, 1'b0, "R1");
    rst_n = 1'b1;
    en = 1'b1;
    tcnt = next_gap();
    hold_low = 0;
    for (int cyc = 0; cyc < 30000; cyc++) begin
      @(negedge clk);
      model_step(tick, en);
      if (cyc == 0) begin
        check(ssi_clk, 1'b1, "R1");
        check(frame_act, 1'b0, "R1");
      end
      check(ssi_clk, m_line, m_busy ? "R3" : "R5");
      check(frame_act, m_busy, "R6");
      // measurements from the ports
      if (!p_frame && tick) begin
        gap_ticks++;
        if (!en) en_gap_low = 1;
      end
      if (frame_act && !en) en_dropped = 1;
      if (p_ssi && !ssi_clk) falls++;
      if (!p_frame && frame_act) begin
        check(ssi_clk, 1'b0, "R6");
        if (en_gap_low) begin
          vectors++;
          if (gap_ticks < GAP + 1) begin
            fails++;
            $display("FAIL R8: got %0d gap ticks expected >= %0d", gap_ticks, GAP + 1);
          end
        end else check_int(gap_ticks, GAP + 1, "R4");
        falls = 1; en_dropped = !en;
      end
      if (p_frame && !frame_act) begin
        check(ssi_clk, 1'b1, "R6");
        check_int(falls, BITS, en_dropped ? "R7" : "R2");
        frames++;
        gap_ticks = 0; en_gap_low = 0; falls = 0;
      end
      p_ssi = ssi_clk; p_frame = frame_act;
      // next stimulus
      tcnt--;
      if (tcnt == 0) begin tick = 1'b1; tcnt = next_gap(); end
      else tick = 1'b0;
      if (cyc >= 8000 && cyc < 9500) en = 1'b0;                 // R8 long hold-off
      else if (hold_low > 0) begin hold_low--; en = 1'b0; end
      else begin
        en = 1'b1;
        if (cyc > 2000 && frame_act && ($urandom % 40) == 0) hold_low = 1 + int'($urandom % 60); // R7
      end
    end
    check_int((frames > 40) ? 1 : 0, 1, "R2");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule